// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block decides which of several pending events a processor core should service next and then carries out the hardware part of entering the handler. The candidates are a trap raised by the previous instruction, a non-maskable request, a maskable request, and faults from instruction fetch, from decode and from execution. The maskable request is considered only when the interrupt enable bit of the incoming flags word is set.

Once an event wins, the sequencer writes the return state onto the stack, one 32-bit word per write. The old stack segment and stack pointer are written only on a privilege change, and the fault error code is written only when one is supplied. After the pushes it reads one entry of a 256-entry vector table and loads the new code segment and instruction pointer from it. Every memory access waits for a ready handshake. The core sees a busy flag for the whole sequence and a one-cycle done pulse at the end.

Top module: `intr_entry_seq`

## Requirements
- R1: When several sources are pending in an idle cycle, exactly one wins, in this order from highest to lowest: previous-instruction trap (vector 1), non-maskable request (vector 2), maskable request (vector from `irq_vec`), fetch fault (`ftch_vec`), decode fault (`dec_vec`), execution fault (`exe_vec`). The winner appears on `vec_out`.
- R2: The maskable request is taken only if bit 9 of `eflags_in` is 1; otherwise it has no effect. The non-maskable request is taken whatever that bit holds.
- R3: When `priv_chg` is 1 at acceptance, the first two writes are `ss_in` zero-extended to 32 bits and then the original `esp_in`.
- R4: The next write is the original `eflags_in`. After that write completes, `eflags_out` equals `eflags_in` with bit 9 (interrupt enable) and bit 8 (trap) cleared. All other bits are kept.
- R5: `cs_in` (zero-extended) and then `eip_in` follow the flags. The error code `err_code` is written last, and only when the winner is one of the three faults and `err_vld` is 1.
- R6: Each write goes to the current stack pointer minus 4, and the stack pointer then drops by 4. At the end, `esp_out` equals `esp_in` minus 4 times the number of writes.
- R7: After the pushes, one read is made at address 4 × vector (the table base is 0 by default). Read data bits 31:16 load `cs_out`, and bits 15:0, zero-extended, load `eip_out`. `done` is high for exactly the one cycle after that read completes.
- R8: An access is held, with the same address and data, until `mem_rdy` is 1 in the same cycle. The sequence does not advance without `mem_rdy`.
- R9: `busy` is 1 from the cycle after acceptance until `done`. Requests are sampled only while idle, so a request raised and dropped while busy starts no further sequence.
- R10: After reset, `busy`, `done`, `mem_wr` and `mem_rd` are 0, and `eflags_out`, `esp_out`, `cs_out`, `eip_out` and `vec_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 1 | Maskable request |
| irq_vec | input | 8 | Vector of the maskable request |
| nmi | input | 1 | Non-maskable request |
| trap | input | 1 | Trap from the previous instruction |
| ftch_flt | input | 1 | Fetch fault |
| ftch_vec | input | 8 | Fetch fault vector |
| dec_flt | input | 1 | Decode fault |
| dec_vec | input | 8 | Decode fault vector |
| exe_flt | input | 1 | Execution fault |
| exe_vec | input | 8 | Execution fault vector |
| err_vld | input | 1 | Error code accompanies a fault |
| err_code | input | W | Error code value |
| priv_chg | input | 1 | Entry changes privilege level |
| eflags_in | input | W | Current flags word |
| cs_in | input | 16 | Current code segment |
| eip_in | input | W | Current instruction pointer |
| ss_in | input | 16 | Current stack segment |
| esp_in | input | W | Current stack pointer |
| mem_rdy | input | 1 | Memory completes the current access |
| mem_rdata | input | W | Vector table read data |
| mem_wr | output | 1 | Stack write request |
| mem_rd | output | 1 | Vector read request |
| mem_addr | output | W | Access address |
| mem_wdata | output | W | Stack write data |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle pulse at the end of the sequence |
| eflags_out | output | W | Flags with interrupt enable and trap cleared |
| esp_out | output | W | Updated stack pointer |
| cs_out | output | 16 | New code segment |
| eip_out | output | W | New instruction pointer |
| vec_out | output | 8 | Vector being serviced |

## Verification
The bench pends several sources at once in many combinations. A design whose priority is wrong takes the wrong vector and reads the wrong table entry. Other cases offer a maskable request with interrupts disabled, where a faulty design would start a sequence or mask a lower fault. An error code supplied with an external request must not be pushed, while one supplied with a fault must; getting this wrong shifts the final stack pointer and the write log. Wait states on memory, and a non-maskable request raised mid-sequence, expose a design that advances early or re-arms while busy.

// File: rtl/intr_entry_seq.sv
module intr_entry_seq #(
  parameter int          W        = 32,
  parameter logic [31:0] VEC_BASE = 32'h0,
  parameter int          IF_BIT   = 9,
  parameter int          TF_BIT   = 8,
  parameter logic [7:0]  TRAP_VEC = 8'd1,
  parameter logic [7:0]  NMI_VEC  = 8'd2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         irq,
  input  logic [7:0]   irq_vec,
  input  logic         nmi,
  input  logic         trap,
  input  logic         ftch_flt,
  input  logic [7:0]   ftch_vec,
  input  logic         dec_flt,
  input  logic [7:0]   dec_vec,
  input  logic         exe_flt,
  input  logic [7:0]   exe_vec,
  input  logic         err_vld,
  input  logic [W-1:0] err_code,
  input  logic         priv_chg,
  input  logic [W-1:0] eflags_in,
  input  logic [15:0]  cs_in,
  input  logic [W-1:0] eip_in,
  input  logic [15:0]  ss_in,
  input  logic [W-1:0] esp_in,
  input  logic         mem_rdy,
  input  logic [W-1:0] mem_rdata,
  output logic         mem_wr,
  output logic         mem_rd,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] eflags_out,
  output logic [W-1:0] esp_out,
  output logic [15:0]  cs_out,
  output logic [W-1:0] eip_out,
  output logic [7:0]   vec_out
);
  localparam logic [W-1:0] SLOT  = W'(W / 8);
  localparam logic [W-1:0] VBASE = W'(VEC_BASE);

  typedef enum logic [2:0] {S_IDLE, S_SS, S_ESP, S_FL, S_CS, S_IP, S_ERR, S_VEC} st_t;

  st_t          state, nxt;
  logic         take, is_flt, has_err;
  logic [7:0]   sel_vec;
  logic [15:0]  l_ss, l_cs;
  logic [W-1:0] l_esp, l_fl, l_eip, l_err;

  always_comb begin
    take    = 1'b1;
    is_flt  = 1'b0;
    sel_vec = 8'd0;
    if (trap)                           sel_vec = TRAP_VEC;
    else if (nmi)                       sel_vec = NMI_VEC;
    else if (irq && eflags_in[IF_BIT])  sel_vec = irq_vec;
    else if (ftch_flt) begin            sel_vec = ftch_vec; is_flt = 1'b1; end
    else if (dec_flt) begin             sel_vec = dec_vec;  is_flt = 1'b1; end
    else if (exe_flt) begin             sel_vec = exe_vec;  is_flt = 1'b1; end
    else                                take = 1'b0;
  end

  always_comb begin
    case (state)
      S_SS:    nxt = S_ESP;
      S_ESP:   nxt = S_FL;
      S_FL:    nxt = S_CS;
      S_CS:    nxt = S_IP;
      S_IP:    nxt = has_err ? S_ERR : S_VEC;
      default: nxt = S_VEC;
    endcase
  end

  assign busy     = (state != S_IDLE);
  assign mem_rd   = (state == S_VEC);
  assign mem_wr   = busy && !mem_rd;
  assign mem_addr = mem_rd ? VBASE + W'({vec_out, 2'b00}) : esp_out - SLOT;

  always_comb begin
    case (state)
      S_SS:    mem_wdata = W'(l_ss);
      S_ESP:   mem_wdata = l_esp;
      S_FL:    mem_wdata = l_fl;
      S_CS:    mem_wdata = W'(l_cs);
      S_IP:    mem_wdata = l_eip;
      S_ERR:   mem_wdata = l_err;
      default: mem_wdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      done       <= 1'b0;
      has_err    <= 1'b0;
      vec_out    <= '0;
      l_ss       <= '0;
      l_cs       <= '0;
      l_esp      <= '0;
      l_fl       <= '0;
      l_eip      <= '0;
      l_err      <= '0;
      eflags_out <= '0;
      esp_out    <= '0;
      cs_out     <= '0;
      eip_out    <= '0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (take) begin
          vec_out    <= sel_vec;
          has_err    <= is_flt && err_vld;
          l_err      <= err_code;
          l_ss       <= ss_in;
          l_cs       <= cs_in;
          l_esp      <= esp_in;
          l_fl       <= eflags_in;
          l_eip      <= eip_in;
          eflags_out <= eflags_in;
          esp_out    <= esp_in;
          state      <= priv_chg ? S_SS : S_FL;
        end
      end else if (mem_rdy) begin
        if (state == S_VEC) begin
          cs_out  <= mem_rdata[W-1 -: 16];
          eip_out <= W'(mem_rdata[15:0]);
          done    <= 1'b1;
          state   <= S_IDLE;
        end else begin
          esp_out <= esp_out - SLOT;
          if (state == S_FL) begin
            eflags_out[IF_BIT] <= 1'b0;
            eflags_out[TF_BIT] <= 1'b0;
          end
          state <= nxt;
        end
      end
    end
  end
endmodule

// File: rtl/intr_entry_seq_chk.sv
module intr_entry_seq_chk #(
  parameter int          W        = 32,
  parameter logic [31:0] VEC_BASE = 32'h0,
  parameter int          IF_BIT   = 9,
  parameter int          TF_BIT   = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mem_wr,
  input logic         mem_rd,
  input logic         mem_rdy,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] eflags_out,
  input logic [W-1:0] esp_out,
  input logic [7:0]   vec_out
);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_wr || mem_rd));

  // R8
  hold_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_wr || mem_rd) && !mem_rdy) |=>
      ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_wr) && $stable(mem_rd)));

  // R6
  sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_rdy) |=> (esp_out == $past(esp_out) - W'(W / 8)));

  // R7
  vec_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr == W'(VEC_BASE) + W'({vec_out, 2'b00})));

  // R7
  done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_rdy) |=> (done && !busy));

  // R4
  flags_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!eflags_out[IF_BIT] && !eflags_out[TF_BIT]));

  // R9
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wr, mem_rd}));
endmodule

bind intr_entry_seq intr_entry_seq_chk #(
  .W(W), .VEC_BASE(VEC_BASE), .IF_BIT(IF_BIT), .TF_BIT(TF_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_rdy(mem_rdy),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .done(done),
  .eflags_out(eflags_out), .esp_out(esp_out), .vec_out(vec_out)
);

// File: tb/intr_entry_seq_tb.sv
module intr_entry_seq_tb;
  logic        clk = 0, rst_n = 0;
  logic        irq = 0, nmi = 0, trap = 0, ftch_flt = 0, dec_flt = 0, exe_flt = 0;
  logic [7:0]  irq_vec = 8'h40, ftch_vec = 8'h03, dec_vec = 8'h06, exe_vec = 8'h0d;
  logic        err_vld = 0, priv_chg = 0, mem_rdy = 0;
  logic [31:0] err_code = 32'hE0C0_0011, eflags_in = 0, eip_in = 32'h0040_1234, esp_in = 32'h0000_8000;
  logic [15:0] cs_in = 16'h001B, ss_in = 16'h0023;
  logic [31:0] mem_rdata;
  logic        mem_wr, mem_rd, busy, done;
  logic [31:0] mem_addr, mem_wdata, eflags_out, esp_out, eip_out;
  logic [15:0] cs_out;
  logic [7:0]  vec_out;

  int total = 0, bad = 0, cyc = 0, ws = 0, wcnt = 0, nw = 0;
  logic [31:0] la [8];
  logic [31:0] ld [8];

  always #10 clk = ~clk;

  assign mem_rdata = {8'h10, mem_addr[9:2], 8'h20, mem_addr[9:2]};

  intr_entry_seq u_dut (.*);

  always @(negedge clk) begin
    if (mem_rdy) begin
      mem_rdy = 1'b0;
      wcnt = 0;
    end else if (mem_wr || mem_rd) begin
      if (wcnt >= ws) begin
        mem_rdy = 1'b1;
        if (mem_wr && nw < 8) begin la[nw] = mem_addr; ld[nw] = mem_wdata; end
        if (mem_wr) nw++;
      end else wcnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d cycles exp=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // {trap,nmi,irq,ftch,dec,exe}, ifl, priv, errv, experr, vec
  localparam int NC = 10;
  localparam logic [17:0] CASES [NC] = '{
    {6'b100000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01},
    {6'b111111, 1'b1, 1'b0, 1'b1, 1'b0, 8'h01},
    {6'b011111, 1'b1, 1'b1, 1'b0, 1'b0, 8'h02},
    {6'b001111, 1'b1, 1'b0, 1'b0, 1'b0, 8'h40},
    {6'b001111, 1'b0, 1'b0, 1'b1, 1'b1, 8'h03},
    {6'b000011, 1'b0, 1'b0, 1'b0, 1'b0, 8'h06},
    {6'b000001, 1'b1, 1'b1, 1'b1, 1'b1, 8'h0d},
    {6'b010000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02},
    {6'b001000, 1'b1, 1'b1, 1'b1, 1'b0, 8'h40},
    {6'b000001, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0d}
  };

  task automatic run_case(input logic [17:0] c, input int wst);
    logic [31:0] ea [8];
    logic [31:0] ed [8];
    logic [31:0] fl;
    int n = 0;
    ws = wst;
    fl = 32'h00A5_0DD5 | (32'(c[11]) << 9);
    eflags_in = fl;
    priv_chg = c[10];
    err_vld = c[9];
    esp_in = esp_in + 32'h100;
    nw = 0;
    {trap, nmi, irq, ftch_flt, dec_flt, exe_flt} = c[17:12];
    do @(negedge clk); while (!busy);
    {trap, nmi, irq, ftch_flt, dec_flt, exe_flt} = 6'b0;
    do @(negedge clk); while (!done);
    if (c[10]) begin ed[n] = {16'h0, ss_in}; n++; ed[n] = esp_in; n++; end
    ed[n] = fl; n++;
    ed[n] = {16'h0, cs_in}; n++;
    ed[n] = eip_in; n++;
    if (c[8]) begin ed[n] = err_code; n++; end
    for (int i = 0; i < n; i++) ea[i] = esp_in - 32'(4 * (i + 1));
    chk(vec_out == c[7:0], "R1 vector", 32'(vec_out), 32'(c[7:0]));
    chk(nw == n, "R5 write count", 32'(nw), 32'(n));
    for (int i = 0; i < n && i < nw; i++) begin
      chk(ld[i] == ed[i], (i < 2 && c[10]) ? "R3 push data" : "R5 push data", ld[i], ed[i]);
      chk(la[i] == ea[i], "R6 push address", la[i], ea[i]);
    end
    chk(esp_out == esp_in - 32'(4 * n), "R6 final sp", esp_out, esp_in - 32'(4 * n));
    chk(eflags_out == (fl & ~32'h300), "R4 flags", eflags_out, fl & ~32'h300);
    chk(cs_out == {8'h10, c[7:0]}, "R7 cs", 32'(cs_out), {16'h0, 8'h10, c[7:0]});
    chk(eip_out == {16'h0, 8'h20, c[7:0]}, "R7 eip", eip_out, {16'h0, 8'h20, c[7:0]});
    @(negedge clk);
    chk(!done && !busy, "R7 done one cycle", {30'h0, done, busy}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_wr && !mem_rd, "R10 reset ctl", {28'h0, busy, done, mem_wr, mem_rd}, 32'h0);
    chk(eflags_out == 0 && esp_out == 0 && cs_out == 0 && eip_out == 0 && vec_out == 0,
        "R10 reset data", esp_out | eip_out, 32'h0);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < NC; k++) run_case(CASES[k], k % 3);

    // R2: masked maskable request alone starts nothing
    eflags_in = 32'h0000_0002; irq = 1; nw = 0;
    repeat (10) @(negedge clk);
    chk(!busy && nw == 0, "R2 masked irq ignored", {31'h0, busy}, 32'h0);
    irq = 0;
    @(negedge clk);

    // R8: withheld ready stalls the first write
    ws = 40; eflags_in = 32'h0000_0202; priv_chg = 0; err_vld = 0; nw = 0; exe_flt = 1;
    do @(negedge clk); while (!busy);
    exe_flt = 0;
    repeat (20) @(negedge clk);
    chk(busy && mem_wr && esp_out == esp_in, "R8 stall sp", esp_out, esp_in);
    chk(mem_addr == esp_in - 4 && nw == 0, "R8 stall addr", mem_addr, esp_in - 4);
    do @(negedge clk); while (!done);
    chk(nw == 3 && vec_out == 8'h0d, "R8 completes", 32'(nw), 32'd3);
    ws = 0;

    // R9: request raised while busy is not taken later
    nw = 0; dec_flt = 1; ws = 2;
    do @(negedge clk); while (!busy);
    dec_flt = 0;
    repeat (3) @(negedge clk);
    nmi = 1;
    @(negedge clk);
    nmi = 0;
    do @(negedge clk); while (!done);
    repeat (10) @(negedge clk);
    chk(!busy && nw == 3, "R9 no second entry", 32'(nw), 32'd3);
    chk(vec_out == 8'h06, "R9 vector kept", 32'(vec_out), 32'h6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule